// File: doc/BRIEF.md
# Encoded Ratio Clock Divider

This block derives a slow output clock from one of several source clock enables. A single configuration register, written and read through a plain write strobe and a read-back bus, holds two fields. The divide field is turned into a ratio N by a parameterised rule: N = (field + OFFSET) × STEP. When the divide field is zero and ZERO_RATIO is nonzero, ZERO_RATIO is used instead. When the divide field has no bits (DIV_W = 0), N is always 1. The select field chooses which source tick drives the divider. A code at or beyond the number of populated sources means "no clock".

Each source is modelled as a one-cycle tick enable in the block's own clock domain. The divider counts ticks of the applied source. Its output is high for floor(N/2) ticks and low for the remaining ticks. For N = 1 the output stays high. A decoded ratio of zero, which arises only from OFFSET = 0 together with ZERO_RATIO = 0, is treated as 1. The status outputs report the applied ratio, the applied select code and a running flag. Software can compute the output rate from these: the source rate divided by the ratio, or zero when stopped.

The control is a three-state machine:
- STOP: no clock; the output is low.
- HIGH: the first part of a period.
- LOW: the rest of the period.

Its transitions are:
- START (STOP→HIGH): a valid select code is pending.
- HALF (HIGH→LOW): the high ticks are used up and N > 1.
- WRAP (LOW→HIGH, or HIGH→HIGH when N = 1): a period ends and the pending configuration is valid.
- HALT (LOW or HIGH→STOP): a period ends and the pending select code is invalid.

Configuration is loaded only on START and WRAP, so no runt pulse is produced.

Top module: `ratio_clk_div`

## Requirements
- R1: The configuration register resets to CFG_RESET (default 0). A write stores only the divide field (bits 2:0 by default) and the select field (bits 9:8 by default). `rd_data_o` returns the stored value with every other bit zero, so writing 0xFFFFFFFF reads back 0x00000307.
- R2: The ratio is (field + OFFSET) × STEP. With the default 3-bit field, OFFSET 1 and STEP 1, field values 0..7 give ratios 1..8.
- R3: When the divide field is zero and ZERO_RATIO is nonzero, the ratio is ZERO_RATIO. With a 5-bit field at bits 20:16, STEP 2, OFFSET 0 and ZERO_RATIO 40, field 0 gives 40 and field 3 gives 6.
- R4: With DIV_W = 0 the ratio is 1 whatever is written, and the output stays high while running.
- R5: A select code at or above NUM_SRC (code 3 by default) stops the divider at the end of the current period. The output is then held low, `running_o` is 0, `ratio_o` is 0, `src_o` shows the code and no rise pulse appears.
- R6: In steady state, consecutive `div_rise_o` pulses are N source ticks apart.
- R7: Within a period the output is high for floor(N/2) source ticks and low for the rest. For N = 1 it is high for the whole period.
- R8: A written configuration takes effect only at the next period start. A write captured on the same edge as a period end applies from the period after it.
- R9: Once applied, `ratio_o` holds N and `src_o` holds the applied select code.
- R10: During reset the output, `running_o`, `ratio_o` and `div_rise_o` are 0. If the reset configuration is valid, the first period starts on the first edge after reset release, with `div_rise_o` high.
- R11: From STOP, a write with a valid select code captured on edge e starts a period on edge e+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | CFG_W | Configuration write data |
| rd_data_o | output | CFG_W | Configuration read-back |
| src_tick_i | input | NUM_SRC | One tick enable per source clock |
| div_clk_o | output | 1 | Divided clock level |
| div_rise_o | output | 1 | One-cycle pulse at each period start |
| ratio_o | output | RATIO_W | Applied ratio, 0 when stopped |
| src_o | output | SEL_W | Applied select code |
| running_o | output | 1 | High when a valid source is being divided |

## Verification
A configuration write and a period-end reload (WRAP) can land on the same clock edge. The bench provokes this by running at ratio 4 on the every-cycle source. It counts three cycles after an observed rise and then raises the write strobe, so that the capture edge is exactly the next WRAP edge. The scoreboard is preloaded with two more periods at the old ratio followed by the new one. A design that loads the freshly written value on that edge shows a short period and is reported.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_HIGH = 2'd1,
        ST_LOW  = 2'd2
    } div_state_t;

    // Width needed to hold the largest ratio the decode rule can produce.
    function automatic int calc_ratio_w(input int div_w, input int offset,
                                        input int step, input int zero_ratio);
        int top_field;
        int m;
        top_field = (div_w == 0) ? 0 : ((1 << div_w) - 1);
        m = (div_w == 0) ? 1 : (top_field + offset) * step;
        if (zero_ratio > m) m = zero_ratio;
        if (m < 1) m = 1;
        return $clog2(m + 1);
    endfunction

    // Bit mask of a field of width w starting at bit lsb.
    function automatic logic [63:0] field_mask(input int lsb, input int w);
        if (w == 0) return 64'd0;
        return ((64'd1 << w) - 64'd1) << lsb;
    endfunction

endpackage

// File: rtl/rcd_cfg_reg.sv
module rcd_cfg_reg
    import rcd_pkg::*;
#(
    parameter int CFG_W     = 32,
    parameter int DIV_LSB   = 0,
    parameter int DIV_W     = 3,
    parameter int SEL_LSB   = 8,
    parameter int SEL_W     = 2,
    parameter logic [CFG_W-1:0] CFG_RESET = '0
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             wr_en_i,
    input  logic [CFG_W-1:0] wr_data_i,
    output logic [CFG_W-1:0] cfg_o
);
    localparam logic [CFG_W-1:0] KEEP =
        CFG_W'(field_mask(DIV_LSB, DIV_W) | field_mask(SEL_LSB, SEL_W));

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cfg_q <= CFG_RESET & KEEP;
        end else if (wr_en_i) begin
            cfg_q <= wr_data_i & KEEP;
        end
    end

    assign cfg_o = cfg_q;

    // R1: bits outside the two fields never hold a one
    a_r1_unused_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (cfg_q & ~KEEP) == '0);
endmodule

// File: rtl/rcd_ratio_decode.sv
module rcd_ratio_decode #(
    parameter int DIV_W      = 3,
    parameter int FW         = 3,
    parameter int OFFSET     = 1,
    parameter int STEP       = 1,
    parameter int ZERO_RATIO = 0,
    parameter int RATIO_W    = 4
) (
    input  logic [FW-1:0]      field_i,
    output logic [RATIO_W-1:0] ratio_o
);
    generate
        if (DIV_W == 0) begin : g_fixed
            assign ratio_o = RATIO_W'(1);
        end else begin : g_rule
            always_comb begin
                int prod;
                prod = (int'(field_i) + OFFSET) * STEP;
                if ((field_i == '0) && (ZERO_RATIO != 0)) begin
                    ratio_o = RATIO_W'(ZERO_RATIO);
                end else if (prod == 0) begin
                    ratio_o = RATIO_W'(1);
                end else begin
                    ratio_o = RATIO_W'(prod);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/rcd_src_sel.sv
module rcd_src_sel #(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] tick_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);
    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            assign hit[i] = tick_i[i] && (sel_i == SEL_W'(i));
        end
    endgenerate

    // An unpopulated code matches no source, so no tick passes.
    assign tick_o = |hit;
endmodule

// File: rtl/rcd_div_fsm.sv
module rcd_div_fsm
    import rcd_pkg::*;
#(
    parameter int RATIO_W = 4,
    parameter int SEL_W   = 2,
    parameter int NUM_SRC = 3
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               tick_i,
    input  logic               pend_valid_i,
    input  logic [RATIO_W-1:0] pend_ratio_i,
    input  logic [SEL_W-1:0]   pend_sel_i,
    output logic [SEL_W-1:0]   sel_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               div_clk_o,
    output logic               rise_o,
    output logic               running_o
);
    div_state_t         state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic [SEL_W-1:0]   sel_q, sel_d;
    logic               rise_q, rise_d;
    logic [RATIO_W-1:0] half;
    logic               period_end;

    assign half = ratio_q >> 1;

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
            ratio_q <= '0;
            sel_q   <= '0;
            rise_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            sel_q   <= sel_d;
            rise_q  <= rise_d;
        end
    end

    // Next state: configuration is loaded only on START and WRAP
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        ratio_d    = ratio_q;
        sel_d      = sel_q;
        rise_d     = 1'b0;
        period_end = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                sel_d = pend_sel_i;
                if (pend_valid_i) begin      // START
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                    ratio_d = pend_ratio_i;
                    rise_d  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick_i) begin
                    if (ratio_q == RATIO_W'(1)) begin
                        period_end = 1'b1;
                    end else if (cnt_q == half - RATIO_W'(1)) begin
                        state_d = ST_LOW;    // HALF
                        cnt_d   = cnt_q + RATIO_W'(1);
                    end else begin
                        cnt_d   = cnt_q + RATIO_W'(1);
                    end
                end
            end
            ST_LOW: begin
                if (tick_i) begin
                    if (cnt_q == ratio_q - RATIO_W'(1)) begin
                        period_end = 1'b1;
                    end else begin
                        cnt_d = cnt_q + RATIO_W'(1);
                    end
                end
            end
            default: state_d = ST_STOP;
        endcase
        if (period_end) begin
            cnt_d = '0;
            sel_d = pend_sel_i;
            if (pend_valid_i) begin          // WRAP
                state_d = ST_HIGH;
                ratio_d = pend_ratio_i;
                rise_d  = 1'b1;
            end else begin                   // HALT
                state_d = ST_STOP;
                ratio_d = '0;
            end
        end
    end

    // Outputs
    always_comb begin
        div_clk_o = 1'b0;
        running_o = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                div_clk_o = 1'b0;
                running_o = 1'b0;
            end
            ST_HIGH: begin
                div_clk_o = 1'b1;
                running_o = 1'b1;
            end
            ST_LOW: begin
                div_clk_o = 1'b0;
                running_o = 1'b1;
            end
            default: begin
                div_clk_o = 1'b0;
                running_o = 1'b0;
            end
        endcase
    end

    assign ratio_o = ratio_q;
    assign sel_o   = sel_q;
    assign rise_o  = rise_q;

    // R8: the applied ratio changes only where a period starts or the divider halts
    a_r8_ratio_only_at_rise: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !$stable(ratio_q) |-> (rise_q || !running_o));
    // R6: the tick count stays inside the period
    a_r6_cnt_in_period: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        running_o |-> (cnt_q < ratio_q));
    // R7: the high phase never runs past floor(N/2) ticks
    a_r7_high_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (div_clk_o && (ratio_q > RATIO_W'(1))) |-> (cnt_q < half));
    // R5: a stopped divider reports rate zero and no clock
    a_r5_stop_no_clock: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !running_o |-> (!div_clk_o && (ratio_q == '0) && !rise_q));
    // R5: a period only starts on a populated source
    a_r5_rise_on_valid_src: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rise_q |-> (int'(sel_q) < NUM_SRC));
    // R10: every period starts with the output high
    a_r10_rise_high: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rise_q |-> div_clk_o);
endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
    import rcd_pkg::*;
#(
    parameter int CFG_W      = 32,
    parameter int DIV_LSB    = 0,
    parameter int DIV_W      = 3,
    parameter int OFFSET     = 1,
    parameter int STEP       = 1,
    parameter int ZERO_RATIO = 0,
    parameter int SEL_LSB    = 8,
    parameter int SEL_W      = 2,
    parameter int NUM_SRC    = 3,
    parameter logic [CFG_W-1:0] CFG_RESET = '0,
    localparam int RATIO_W   = calc_ratio_w(DIV_W, OFFSET, STEP, ZERO_RATIO)
) (
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               wr_en_i,
    input  logic [CFG_W-1:0]   wr_data_i,
    output logic [CFG_W-1:0]   rd_data_o,
    input  logic [NUM_SRC-1:0] src_tick_i,
    output logic               div_clk_o,
    output logic               div_rise_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [SEL_W-1:0]   src_o,
    output logic               running_o
);
    localparam int FW = (DIV_W > 0) ? DIV_W : 1;

    logic [CFG_W-1:0]   cfg_q;
    logic [FW-1:0]      div_field;
    logic [SEL_W-1:0]   pend_sel;
    logic [RATIO_W-1:0] pend_ratio;
    logic               pend_valid;
    logic [SEL_W-1:0]   applied_sel;
    logic               applied_tick;

    rcd_cfg_reg #(
        .CFG_W(CFG_W), .DIV_LSB(DIV_LSB), .DIV_W(DIV_W),
        .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .CFG_RESET(CFG_RESET)
    ) u_cfg (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_en_i(wr_en_i),
        .wr_data_i(wr_data_i), .cfg_o(cfg_q)
    );

    generate
        if (DIV_W > 0) begin : g_div_field
            assign div_field = cfg_q[DIV_LSB +: FW];
        end else begin : g_no_div_field
            assign div_field = '0;
        end
    endgenerate

    assign pend_sel   = cfg_q[SEL_LSB +: SEL_W];
    assign pend_valid = int'(pend_sel) < NUM_SRC;

    rcd_ratio_decode #(
        .DIV_W(DIV_W), .FW(FW), .OFFSET(OFFSET), .STEP(STEP),
        .ZERO_RATIO(ZERO_RATIO), .RATIO_W(RATIO_W)
    ) u_decode (
        .field_i(div_field), .ratio_o(pend_ratio)
    );

    rcd_src_sel #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sel (
        .tick_i(src_tick_i), .sel_i(applied_sel), .tick_o(applied_tick)
    );

    rcd_div_fsm #(.RATIO_W(RATIO_W), .SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_fsm (
        .clk_i(clk_i), .rst_n_i(rst_n_i), .tick_i(applied_tick),
        .pend_valid_i(pend_valid), .pend_ratio_i(pend_ratio), .pend_sel_i(pend_sel),
        .sel_o(applied_sel), .ratio_o(ratio_o), .div_clk_o(div_clk_o),
        .rise_o(div_rise_o), .running_o(running_o)
    );

    assign rd_data_o = cfg_q;
    assign src_o     = applied_sel;

    // R2: a running divider never reports a zero ratio
    a_r2_ratio_nonzero: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        running_o |-> (ratio_o != '0));
endmodule

// File: tb/ratio_clk_div_bench.sv
module ratio_clk_div_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int tick_n  = 0;
    logic [2:0] src_tick = 3'b111;

    // source 0 every cycle, source 1 every 2nd, source 2 every 3rd
    always @(negedge clk) begin
        tick_n   <= tick_n + 1;
        src_tick <= {((tick_n + 1) % 3) == 0, ((tick_n + 1) % 2) == 0, 1'b1};
    end
    always @(posedge clk) cyc <= cyc + 1;

    // main instance
    logic        m_wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] m_rd;
    logic        m_clk, m_rise, m_run;
    logic [3:0]  m_ratio;
    logic [1:0]  m_src;

    ratio_clk_div u_ratio_clk_div (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(m_wr), .wr_data_i(wdata),
        .rd_data_o(m_rd), .src_tick_i(src_tick), .div_clk_o(m_clk),
        .div_rise_o(m_rise), .ratio_o(m_ratio), .src_o(m_src), .running_o(m_run)
    );

    // zero-ratio instance: 5-bit field at 20:16, STEP 2, OFFSET 0, ZERO_RATIO 40
    logic        z_wr = 1'b0;
    logic [31:0] z_rd;
    logic        z_clk, z_rise, z_run;
    logic [5:0]  z_ratio;
    logic [1:0]  z_src;

    ratio_clk_div #(.DIV_LSB(16), .DIV_W(5), .OFFSET(0), .STEP(2), .ZERO_RATIO(40)) u_zr (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(z_wr), .wr_data_i(wdata),
        .rd_data_o(z_rd), .src_tick_i(src_tick), .div_clk_o(z_clk),
        .div_rise_o(z_rise), .ratio_o(z_ratio), .src_o(z_src), .running_o(z_run)
    );

    // fixed instance: no divide field
    logic        f_wr = 1'b0;
    logic [31:0] f_rd;
    logic        f_clk, f_rise, f_run;
    logic [0:0]  f_ratio;
    logic [1:0]  f_src;

    ratio_clk_div #(.DIV_W(0)) u_fix (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(f_wr), .wr_data_i(wdata),
        .rd_data_o(f_rd), .src_tick_i(src_tick), .div_clk_o(f_clk),
        .div_rise_o(f_rise), .ratio_o(f_ratio), .src_o(f_src), .running_o(f_run)
    );

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // scoreboard
    typedef struct {
        int    period;
        int    high;
        string req;
    } period_item_t;
    period_item_t exp_q[$];

    // monitor: samples 2 ns after each rising edge
    initial begin
        int   prev_cyc = 0;
        int   hcnt = 0;
        logic have_prev = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            if (m_rise) begin
                if (have_prev && exp_q.size() > 0) begin
                    period_item_t it;
                    it = exp_q.pop_front();
                    check_eq(it.req, "period cycles", cyc - prev_cyc, it.period);
                    check_eq(it.req, "high cycles", hcnt, it.high);
                end
                prev_cyc  = cyc;
                hcnt      = 0;
                have_prev = 1'b1;
            end
            if (m_clk) hcnt++;
        end
    end

    task automatic wr_main(input logic [31:0] d);
        @(negedge clk);
        m_wr = 1'b1; wdata = d;
        @(negedge clk);
        m_wr = 1'b0;
    endtask

    task automatic wait_rise_m();
        do @(negedge clk); while (!m_rise);
    endtask

    task automatic wait_rise_z();
        do @(negedge clk); while (!z_rise);
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    function automatic period_item_t mk(input int n, input int sp, input string req);
        period_item_t it;
        it.period = n * sp;
        it.high   = ((n == 1) ? 1 : n / 2) * sp;
        it.req    = req;
        return it;
    endfunction

    task automatic run_case(input logic [31:0] cfg, input int n, input int sel,
                            input int sp, input string req);
        wr_main(cfg);
        wait_rise_m();
        wait_rise_m();
        check_eq("R9", "applied ratio", m_ratio, n);
        check_eq("R9", "applied source", m_src, sel);
        for (int k = 0; k < 3; k++) exp_q.push_back(mk(n, sp, req));
        drain();
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int t0;
        int rises;
        int highs;
        // R10 reset state
        repeat (3) @(negedge clk);
        check_eq("R10", "div_clk in reset", m_clk, 0);
        check_eq("R10", "running in reset", m_run, 0);
        check_eq("R10", "ratio in reset", m_ratio, 0);
        check_eq("R10", "rise in reset", m_rise, 0);
        check_eq("R1", "reset read-back", m_rd, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R10", "running after first edge", m_run, 1);
        check_eq("R10", "rise after first edge", m_rise, 1);
        check_eq("R2", "reset field 0 ratio", m_ratio, 1);

        // R2 R6 R7: ratios over several sources
        run_case(32'h0000_0000, 1, 0, 1, "R2");
        run_case(32'h0000_0007, 8, 0, 1, "R2");
        run_case(32'h0000_0102, 3, 1, 2, "R7");
        run_case(32'h0000_0203, 4, 2, 3, "R6");
        run_case(32'h0000_0004, 5, 0, 1, "R7");
        run_case(32'h0000_0101, 2, 1, 2, "R6");
        run_case(32'h0000_0003, 4, 0, 1, "R6");

        // R8: write captured on the same edge as a period end
        wait_rise_m();
        exp_q.push_back(mk(4, 1, "R8"));
        exp_q.push_back(mk(4, 1, "R8"));
        exp_q.push_back(mk(6, 1, "R8"));
        exp_q.push_back(mk(6, 1, "R8"));
        repeat (3) @(negedge clk);
        m_wr = 1'b1; wdata = 32'h0000_0005;
        @(negedge clk);
        m_wr = 1'b0;
        drain();

        // R5: unpopulated select code stops the divider
        wr_main(32'h0000_0302);
        repeat (20) @(negedge clk);
        check_eq("R5", "running stopped", m_run, 0);
        check_eq("R5", "div_clk stopped", m_clk, 0);
        check_eq("R5", "ratio when stopped", m_ratio, 0);
        check_eq("R5", "src shows code", m_src, 3);
        rises = 0; highs = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (m_rise) rises++;
            if (m_clk) highs++;
        end
        check_eq("R5", "rises while stopped", rises, 0);
        check_eq("R5", "high cycles while stopped", highs, 0);

        // R11: restart timing from STOP
        @(negedge clk);
        m_wr = 1'b1; wdata = 32'h0000_0001;
        @(negedge clk);
        m_wr = 1'b0;
        check_eq("R11", "running at capture edge", m_run, 0);
        @(negedge clk);
        check_eq("R11", "running one edge later", m_run, 1);
        check_eq("R11", "rise one edge later", m_rise, 1);
        check_eq("R11", "ratio after restart", m_ratio, 2);

        // R1: read-back masks unused bits
        wr_main(32'hFFFF_FFFF);
        check_eq("R1", "read-back of all ones", m_rd, 32'h0000_0307);
        wr_main(32'h0000_0000);

        // R3: zero field maps to ZERO_RATIO
        check_eq("R3", "zero field ratio", z_ratio, 40);
        wait_rise_z();
        t0 = cyc;
        wait_rise_z();
        check_eq("R3", "zero field period", cyc - t0, 40);
        @(negedge clk);
        z_wr = 1'b1; wdata = 32'h0003_0000;
        @(negedge clk);
        z_wr = 1'b0;
        wait_rise_z();
        wait_rise_z();
        t0 = cyc;
        wait_rise_z();
        check_eq("R3", "field 3 period", cyc - t0, 6);
        check_eq("R3", "field 3 ratio", z_ratio, 6);

        // R4: no divide field
        @(negedge clk);
        f_wr = 1'b1; wdata = 32'h0000_00FF;
        @(negedge clk);
        f_wr = 1'b0;
        repeat (5) @(negedge clk);
        check_eq("R4", "fixed ratio", f_ratio, 1);
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (f_clk) highs++;
        end
        check_eq("R4", "fixed output high cycles", highs, 10);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule